// File: doc/BRIEF.md
# ADC Input Channel Sequencer

This block is the digital channel-selection logic of a four-input multiplexed converter. The host loads a small control register through a one-cycle write strobe. The register holds the following fields:

- an input-pairing mode;
- a sequencer selection;
- a channel address;
- a reference-select flag.

Each rising edge of the conversion-start input is one conversion request. For each request the block registers the multiplexer channel code for that conversion and raises a one-cycle valid strobe. The pairing output tells the front end whether the code names a single input or a pseudo-differential pair.

The block has two ways of choosing the channel. In fixed operation, every conversion uses the addressed channel, and the host moves to another channel by writing a new address. In sweep operation, conversions step through channel 0, channel 1 and so on up to the addressed final channel, then wrap back to channel 0. A wrap strobe marks the conversion at which the sweep returns to channel 0. Any register write cancels the sweep and starts it again.

Top module: `adc_chan_seq`

## Requirements
- R1: While reset is active, and after it is released, `chan_o`, `conv_valid_o`, `wrap_o`, `pair_mode_o` and `int_ref_o` are all 0. The register clears to 0, which selects fixed operation on channel 0 with the external reference.
- R2: A write loads `wr_data_i` into the register. The register fields are:
  - bits 1:0 are the address;
  - bit 2 is sequencer bit 0 and bit 3 is sequencer bit 1;
  - bit 4 is mode bit 0 and bit 5 is mode bit 1;
  - bit 6 selects the internal reference.

  One cycle after the write, `int_ref_o` equals bit 6. `pair_mode_o` is 1 exactly when bit 4 is 1 and bit 5 is 0.
- R3: A conversion is requested on the first clock edge that samples `conv_start_i` high after it was low. `conv_valid_o` is then high for exactly the next cycle. Holding `conv_start_i` high makes no further request.
- R4: When the two sequencer bits are 00, 01 or 10, every conversion outputs the address on `chan_o`, after the pairing clamp of R8 is applied.
- R5: When both sequencer bits are 1, the first conversion after a write outputs channel 0. Each later conversion outputs the previous channel plus one.
- R6: In sweep operation, the conversion that follows the final channel (the clamped address) outputs channel 0, and the sweep then repeats.
- R7: A write during a sweep cancels it. The next conversion uses the new register contents, and a sweep restarts at channel 0.
- R8: In pseudo-differential mode only pair codes 0 and 1 are output. An address above 1 is clamped to 1, in fixed operation and as the final channel of a sweep.
- R9: `wrap_o` is high together with `conv_valid_o` only for a sweep conversion on channel 0 that is not the first conversion after a write.
- R10: `chan_o` changes only in a cycle where `conv_valid_o` is high. A write alone does not change it.
- R11: If a write and a start edge fall on the same clock edge, the write is applied and that start edge is dropped: no valid strobe follows and `chan_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 7 | Register write data |
| conv_start_i | input | 1 | Conversion start; its rising edge requests a conversion |
| chan_o | output | 2 | Channel or pair code for the current conversion |
| pair_mode_o | output | 1 | 1 = pseudo-differential pairing in effect |
| int_ref_o | output | 1 | 1 = internal reference selected |
| conv_valid_o | output | 1 | One-cycle strobe for each accepted conversion |
| wrap_o | output | 1 | One-cycle strobe when the sweep returns to channel 0 |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it:

- `int_ref_o` and `pair_mode_o` update on the edge that samples the write strobe.
- `chan_o`, `conv_valid_o` and `wrap_o` update on the edge that first samples the start input high.

The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a cycle after the edge that moved them. One cycle after each strobe it reads the outputs again, to confirm that the strobe has dropped and that the channel code has held.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic {
    SEL_FIXED = 1'b0,
    SEL_SWEEP = 1'b1
  } sel_e;

  // mode field value (mode1:mode0) that pairs the inputs
  localparam logic [1:0] MODE_PAIRED = 2'b01;
  localparam logic [1:0] SEQ_SWEEP   = 2'b11;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int CTRL_W = CH_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CH_W-1:0]   addr_o,
  output sel_e              sel_o,
  output logic              pair_o,
  output logic              ref_o
);

  localparam int SEQ_LO  = CH_W;
  localparam int MODE_LO = CH_W + 2;
  localparam int REF_BIT = CH_W + 4;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i;
  end

  always_comb begin
    addr_o = ctrl_q[CH_W-1:0];
    sel_o  = (ctrl_q[SEQ_LO+1:SEQ_LO] == SEQ_SWEEP) ? SEL_SWEEP : SEL_FIXED;
    pair_o = (ctrl_q[MODE_LO+1:MODE_LO] == MODE_PAIRED);
    ref_o  = ctrl_q[REF_BIT];
  end

  p_write_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ref_o == $past(wr_data_i[REF_BIT]));

endmodule

// File: rtl/adc_seq_edge.sv
module adc_seq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic block_i,
  output logic fire_o
);

  logic start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end

  // a write in the same cycle swallows the edge
  assign fire_o = start_i & ~start_q & ~block_i;

  p_single_fire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

endmodule

// File: rtl/adc_seq_sweep.sv
module adc_seq_sweep #(
  parameter int CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            step_i,
  input  logic [CH_W-1:0] last_i,
  output logic [CH_W-1:0] ptr_o,
  output logic            wrap_o
);

  logic [CH_W-1:0] ptr_q;
  logic            started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      started_q <= 1'b0;
    end else if (restart_i) begin
      ptr_q     <= '0;
      started_q <= 1'b0;
    end else if (step_i) begin
      ptr_q     <= (ptr_q == last_i) ? '0 : ptr_q + 1'b1;
      started_q <= 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign wrap_o = step_i & started_q & (ptr_q == '0);

  p_ptr_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= last_i);

  p_restart_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ptr_q == '0);

endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [$clog2(N_CH)+4:0] wr_data_i,
  input  logic                    conv_start_i,
  output logic [$clog2(N_CH)-1:0] chan_o,
  output logic                    pair_mode_o,
  output logic                    int_ref_o,
  output logic                    conv_valid_o,
  output logic                    wrap_o
);

  localparam int CH_W   = $clog2(N_CH);
  localparam int CTRL_W = CH_W + 5;
  localparam int N_PAIR = N_CH / 2;
  localparam logic [CH_W-1:0] LIM_SE   = CH_W'(N_CH - 1);
  localparam logic [CH_W-1:0] LIM_PAIR = CH_W'(N_PAIR - 1);

  logic [CH_W-1:0] addr, lim, last, ptr;
  sel_e            sel;
  logic            pair, fire, sweep_wrap;

  adc_seq_ctrl #(.CH_W(CH_W), .CTRL_W(CTRL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .addr_o   (addr),
    .sel_o    (sel),
    .pair_o   (pair),
    .ref_o    (int_ref_o)
  );

  adc_seq_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(conv_start_i),
    .block_i(wr_en_i),
    .fire_o (fire)
  );

  // clamp address to the last valid code of the pairing mode
  assign lim  = pair ? LIM_PAIR : LIM_SE;
  assign last = (addr > lim) ? lim : addr;

  adc_seq_sweep #(.CH_W(CH_W)) u_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(wr_en_i),
    .step_i   (fire && sel == SEL_SWEEP),
    .last_i   (last),
    .ptr_o    (ptr),
    .wrap_o   (sweep_wrap)
  );

  logic [CH_W-1:0] chan_q;
  logic            valid_q, wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      valid_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      wrap_q  <= sweep_wrap;
      if (fire) chan_q <= (sel == SEL_SWEEP) ? ptr : last;
    end
  end

  assign chan_o       = chan_q;
  assign conv_valid_o = valid_q;
  assign wrap_o       = wrap_q;
  assign pair_mode_o  = pair;

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_valid_o |=> !conv_valid_o);

  p_pair_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_valid_o && pair_mode_o) |-> int'(chan_o) < N_PAIR);

  p_wrap_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (conv_valid_o && chan_o == '0));

  p_chan_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_valid_o |-> $stable(chan_o));

  p_write_drops_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !conv_valid_o);

endmodule

// File: tb/sim_adc_chan_seq.sv
module sim_adc_chan_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic       start = 1'b0;
  logic [1:0] chan;
  logic       pair_mode, int_ref, conv_valid, wrap;

  int errors = 0;
  int checks = 0;

  // model state
  logic [1:0] m_addr = '0, m_seq = '0, m_mode = '0, m_ptr = '0, m_chan = '0;
  logic       m_ref = 1'b0, m_started = 1'b0;

  always #2 clk = ~clk;

  adc_chan_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .conv_start_i(start), .chan_o(chan), .pair_mode_o(pair_mode),
    .int_ref_o(int_ref), .conv_valid_o(conv_valid), .wrap_o(wrap)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_pair();
    return m_mode == 2'b01;
  endfunction

  function automatic logic [1:0] m_last();
    logic [1:0] lim = m_pair() ? 2'd1 : 2'd3;
    return (m_addr > lim) ? lim : m_addr;
  endfunction

  task automatic do_write(logic [6:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_addr = d[1:0]; m_seq = d[3:2]; m_mode = d[5:4]; m_ref = d[6];
    m_ptr = '0; m_started = 1'b0;
    check("R2 int_ref", int_ref, m_ref);
    check("R2 pair_mode", pair_mode, m_pair());
    check("R10 chan after write", chan, m_chan);
    check("R11 no valid after write", conv_valid, 0);
  endtask

  task automatic do_conv();
    logic exp_wrap;
    @(negedge clk);
    start = 1'b1;
    if (m_seq == 2'b11) begin
      m_chan = m_ptr;
      exp_wrap = m_started && m_ptr == 2'd0;
      m_started = 1'b1;
      m_ptr = (m_ptr == m_last()) ? 2'd0 : m_ptr + 2'd1;
    end else begin
      m_chan = m_last();
      exp_wrap = 1'b0;
    end
    @(negedge clk);
    check("R3 valid", conv_valid, 1);
    check(m_seq == 2'b11 ? "R5/R6/R8 sweep chan" : "R4/R8 fixed chan", chan, m_chan);
    check("R9 wrap", wrap, exp_wrap);
    @(negedge clk);
    check("R3 no second valid while held", conv_valid, 0);
    check("R10 chan held", chan, m_chan);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 chan", chan, 0);
    check("R1 valid", conv_valid, 0);
    check("R1 wrap", wrap, 0);
    check("R1 pair", pair_mode, 0);
    check("R1 ref", int_ref, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {chan, conv_valid, wrap, pair_mode, int_ref}, 0);
    do_conv();                       // R1: fixed on channel 0

    // R4 fixed, any order
    do_write(7'h02); do_conv(); do_conv();
    do_write(7'h01); do_conv();
    do_write(7'h07); do_conv();      // seq 01 treated as fixed
    do_write(7'h4B); do_conv();      // seq 10, ref set
    // R5 R6 R9 sweep to 3 with wrap
    do_write(7'h0F);
    repeat (6) do_conv();
    // R7 restart mid sweep
    do_write(7'h0E); do_conv(); do_conv(); do_conv(); do_conv();
    // R8 paired sweep clamps 3 -> 1
    do_write(7'h1F); repeat (5) do_conv();
    // R8 paired fixed clamp
    do_write(7'h13); do_conv();
    // mode 10 is single-ended
    do_write(7'h23); do_conv();
    // final channel 0: every later conversion wraps
    do_write(7'h0C); repeat (3) do_conv();

    // R11 write coincides with start edge
    do_write(7'h0F); do_conv();
    @(negedge clk);
    wr_en = 1'b1; wr_data = 7'h0D; start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_addr = 2'd1; m_seq = 2'b11; m_mode = 2'b00; m_ref = 1'b0;
    m_ptr = '0; m_started = 1'b0;
    check("R11 dropped edge", conv_valid, 0);
    check("R11 chan unchanged", chan, m_chan);
    @(negedge clk);
    check("R11 held start no request", conv_valid, 0);
    start = 1'b0;
    @(negedge clk);
    do_conv();                       // R7 first sweep conversion on 0

    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) do_write(7'($urandom % 128));
      else do_conv();
    end
    finish_run();
  end

endmodule